// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block sits behind the command decoder of a serial nonvolatile memory. It holds the user-visible status byte and decides, at the end of each select, whether a pending array write or status write may go ahead. The block keeps the write-enable latch, a two-bit block-protect code and a protect-enable bit. It also mirrors the programming busy flag into the status byte.

The decoder sends single-cycle command events while chip select is low: write enable, write disable, status write with its data byte, and array write request with its target address. The block registers these events. When chip select returns high it issues a one-cycle grant or deny for each request seen in that select. Software protection covers the upper quarter, the upper half or all of the array. A hardware lock ties the status register to the external write-protect pin whenever protect-enable is set.

Top module: `sr_guard`

## Requirements
- R1: After reset, status_o reads 0x20 with busy_i low, and no grant or deny output is high.
- R2: status_o bit 7 is protect-enable and bits 6..4 read 010. Bits 3..2 are the block-protect code (bit 3 high), bit 1 is the write-enable latch, and bit 0 follows busy_i.
- R3: A write-enable event sets the latch only at the next rise of cs_n_i. An array write in the same select as the write enable is denied.
- R4: A write-disable event clears the latch.
- R5: A status write changes only bits 7, 3 and 2. It takes effect at the rise of cs_n_i only when the latch is set. It is answered by a one-cycle sr_grant_o pulse, or by sr_deny_o when refused.
- R6: Array write decisions use the block-protect code. Code 00 protects nothing, 01 protects addresses 0x600..0x7FF, 10 protects 0x400..0x7FF, and 11 protects the whole array. A write with the latch set is granted outside the protected range and denied inside it.
- R7: The range decision uses only the page number (address bits above the 5-bit page offset), so a page write is accepted or refused as a whole.
- R8: With protect-enable 1 and wp_n_i low, status writes are denied and the status bits stay unchanged, while unprotected array writes are still granted when the latch is set.
- R9: With protect-enable 0, or with wp_n_i high, the pin has no effect on status writes.
- R10: If wp_n_i goes low under a set protect-enable while cs_n_i is low after a status write event, that status write is denied, even if the pin is high again when cs_n_i rises.
- R11: While busy_i is high, write enable, write disable, status write and array write events are ignored. They produce no grant or deny and leave the latch unchanged.
- R12: After any grant, the latch clears when busy_i next falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select state, low while selected |
| busy_i | input | 1 | Internal programming cycle in progress |
| wp_n_i | input | 1 | Write-protect pin, low asserts the hardware lock |
| wren_i | input | 1 | Decoded write-enable event |
| wrdi_i | input | 1 | Decoded write-disable event |
| wrsr_i | input | 1 | Decoded status-write event, data valid on sr_data_i |
| sr_data_i | input | 8 | Status byte to write |
| wr_req_i | input | 1 | Decoded array write request, address valid on addr_i |
| addr_i | input | ADDR_W | Array write start address |
| status_o | output | 8 | Status byte for readout |
| arr_grant_o | output | 1 | One-cycle pulse: array write accepted |
| arr_deny_o | output | 1 | One-cycle pulse: array write refused |
| sr_grant_o | output | 1 | One-cycle pulse: status write accepted |
| sr_deny_o | output | 1 | One-cycle pulse: status write refused |

## Verification
Each decision surfaces one cycle after cs_n_i is first seen high, so an error in the latch or the pending-request state shows up at the first select that ends. It appears as a grant where a deny was due, or the reverse. An error in a protect bit appears on status_o at once, since the byte is a direct readout. The same error also appears at the next array write whose page lies on a range boundary (0x3FF/0x400, 0x5FF/0x600). A missed hardware abort shows only as a status grant at the end of a select in which the pin briefly went low. The bench therefore pulses the pin inside the select and expects a deny.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_code_e;

  localparam int unsigned SR_WPEN_BIT = 7;
  localparam int unsigned SR_BP_HI    = 3;
  localparam int unsigned SR_BP_LO    = 2;

  function automatic logic [7:0] pack_status(logic wpen, bp_code_e bp, logic wel, logic busy);
    return {wpen, 3'b010, bp, wel, busy};
  endfunction
endpackage

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_rise_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic wr_done_i,
  output logic wel_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wel_o  <= 1'b0;
    end else begin
      if (wrdi_i) begin
        pend_q <= 1'b0;
        wel_o  <= 1'b0;
      end else if (wren_i) begin
        pend_q <= 1'b1;
      end else if (cs_rise_i) begin
        pend_q <= 1'b0;
        if (pend_q) wel_o <= 1'b1;
      end else if (wr_done_i) begin
        wel_o <= 1'b0;
      end
    end
  end

  // R3: latch only rises after a registered write-enable
  p_wel_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> $past(pend_q));

  // R4: write-disable always leaves the latch cleared
  p_wel_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i |=> !wel_o);
endmodule

// File: rtl/sr_range_map.sv
module sr_range_map
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 5
) (
  input  bp_code_e            bp_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o
);
  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic [PG_W-1:0] page;
  logic            top_half;
  logic            top_quarter;

  assign page = addr_i[ADDR_W-1:PAGE_W];

  generate
    if (PG_W >= 2) begin : g_pages
      assign top_half    = page[PG_W-1];
      assign top_quarter = page[PG_W-1] & page[PG_W-2];
    end else begin : g_small
      assign top_half    = page[PG_W-1];
      assign top_quarter = page[PG_W-1];
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      BP_NONE:    hit_o = 1'b0;
      BP_QUARTER: hit_o = top_quarter;
      BP_HALF:    hit_o = top_half;
      default:    hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_stat_reg.sv
module sr_stat_reg
  import sr_guard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_rise_i,
  input  logic       cs_low_i,
  input  logic       busy_i,
  input  logic       wrsr_i,
  input  logic [7:0] data_i,
  input  logic       wel_i,
  input  logic       wp_n_i,
  output logic       wpen_o,
  output bp_code_e   bp_o,
  output logic       grant_o,
  output logic       deny_o
);
  logic       req_q;
  logic       pend_q;
  logic [7:0] data_q;
  logic       hw_lock;

  assign hw_lock = wpen_o & ~wp_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
      wpen_o  <= 1'b0;
      bp_o    <= BP_NONE;
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
      if (cs_rise_i) begin
        if (req_q && !busy_i) begin
          if (pend_q && wel_i && !hw_lock) begin
            wpen_o  <= data_q[SR_WPEN_BIT];
            bp_o    <= bp_code_e'(data_q[SR_BP_HI:SR_BP_LO]);
            grant_o <= 1'b1;
          end else begin
            deny_o <= 1'b1;
          end
        end
        req_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (wrsr_i) begin
        req_q  <= 1'b1;
        pend_q <= 1'b1;
        data_q <= data_i;
      end else if (cs_low_i && hw_lock) begin
        pend_q <= 1'b0;  // pin abort while still selected
      end
    end
  end

  // R8: no status commit while the hardware lock held
  p_sr_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !$past(hw_lock));

  // R5: protect bits move only with a granted status write
  p_sr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_o |-> $stable({wpen_o, bp_o}));

  // R5: grant and deny never together
  p_sr_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              busy_i,
  input  logic              wp_n_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              arr_grant_o,
  output logic              arr_deny_o,
  output logic              sr_grant_o,
  output logic              sr_deny_o
);
  logic              cs_q, busy_q;
  logic              cs_rise, cs_low, cmd_ok;
  logic              wel, wpen, hit, wr_done;
  bp_code_e          bp;
  logic              arr_pend_q, done_q;
  logic [ADDR_W-1:0] arr_addr_q;

  assign cs_low  = ~cs_n_i;
  assign cs_rise = cs_n_i & ~cs_q;
  assign cmd_ok  = cs_low & ~busy_i;
  assign wr_done = busy_q & ~busy_i & done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      cs_q   <= cs_n_i;
      busy_q <= busy_i;
    end
  end

  sr_wel_latch u_wel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_rise_i (cs_rise),
    .wren_i    (wren_i & cmd_ok),
    .wrdi_i    (wrdi_i & cmd_ok),
    .wr_done_i (wr_done),
    .wel_o     (wel)
  );

  sr_stat_reg u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_rise_i (cs_rise),
    .cs_low_i  (cs_low),
    .busy_i    (busy_i),
    .wrsr_i    (wrsr_i & cmd_ok),
    .data_i    (sr_data_i),
    .wel_i     (wel),
    .wp_n_i    (wp_n_i),
    .wpen_o    (wpen),
    .bp_o      (bp),
    .grant_o   (sr_grant_o),
    .deny_o    (sr_deny_o)
  );

  sr_range_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_range (
    .bp_i   (bp),
    .addr_i (arr_addr_q),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_pend_q  <= 1'b0;
      arr_addr_q  <= '0;
      arr_grant_o <= 1'b0;
      arr_deny_o  <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      arr_grant_o <= 1'b0;
      arr_deny_o  <= 1'b0;
      if (cs_rise) begin
        if (arr_pend_q && !busy_i) begin
          if (wel && !hit) arr_grant_o <= 1'b1;
          else             arr_deny_o  <= 1'b1;
        end
        arr_pend_q <= 1'b0;
      end else if (wr_req_i && cmd_ok) begin
        arr_pend_q <= 1'b1;
        arr_addr_q <= addr_i;
      end
      if (arr_grant_o || sr_grant_o) done_q <= 1'b1;
      else if (wr_done)              done_q <= 1'b0;
    end
  end

  assign status_o = pack_status(wpen, bp, wel, busy_i);

  // R6: decisions are exclusive
  p_arr_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_grant_o && arr_deny_o));

  // R3: array grant needs the latch already set
  p_arr_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_grant_o |-> $past(wel));

  // R6: no grant inside the protected range
  p_arr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_grant_o |-> !$past(hit));

  // R11: no decision issued while busy
  p_busy_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_grant_o || sr_grant_o) |-> !$past(busy_i));

  // R12: latch drops once a granted write finishes
  p_wel_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> !wel);
endmodule

// File: tb/sr_guard_test.sv
module sr_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, busy = 1'b0, wp_n = 1'b1;
  logic        wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, wr_req = 1'b0;
  logic [7:0]  sr_data = '0;
  logic [10:0] addr = '0;
  logic [7:0]  status;
  logic        ag, ad, sg, sd;
  logic        s_ag, s_ad, s_sg, s_sd;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sr_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .busy_i(busy), .wp_n_i(wp_n),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .sr_data_i(sr_data),
    .wr_req_i(wr_req), .addr_i(addr), .status_o(status),
    .arr_grant_o(ag), .arr_deny_o(ad), .sr_grant_o(sg), .sr_deny_o(sd)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(logic wpen, logic [1:0] bp, logic wel, logic b);
    return {wpen, 3'b010, bp, wel, b};
  endfunction

  task automatic sel();  @(negedge clk) cs_n = 1'b0; endtask
  task automatic desel();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) begin s_ag = ag; s_ad = ad; s_sg = sg; s_sd = sd; end
    @(negedge clk);
  endtask
  task automatic p_wren(); @(negedge clk) wren = 1'b1; @(negedge clk) wren = 1'b0; endtask
  task automatic p_wrdi(); @(negedge clk) wrdi = 1'b1; @(negedge clk) wrdi = 1'b0; endtask
  task automatic p_wrsr(logic [7:0] d);
    @(negedge clk) begin wrsr = 1'b1; sr_data = d; end
    @(negedge clk) wrsr = 1'b0;
  endtask
  task automatic p_wreq(logic [10:0] a);
    @(negedge clk) begin wr_req = 1'b1; addr = a; end
    @(negedge clk) wr_req = 1'b0;
  endtask
  task automatic busy_cycle();
    @(negedge clk) busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask
  task automatic set_wel(); sel(); p_wren(); desel(); endtask

  task automatic do_sr(logic [7:0] d, logic exp, string req);
    set_wel();
    sel(); p_wrsr(d); desel();
    chk(req, {s_sg, s_sd}, {exp, ~exp});
    if (exp) busy_cycle();
    else begin sel(); p_wrdi(); desel(); end
  endtask

  task automatic do_arr(logic [10:0] a, logic exp, string req);
    set_wel();
    sel(); p_wreq(a); desel();
    chk(req, {s_ag, s_ad}, {exp, ~exp});
    if (exp) busy_cycle();
    else begin sel(); p_wrdi(); desel(); end
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h20);
    chk("R1 pulses", {ag, ad, sg, sd}, 8'h0);
    @(negedge clk) busy = 1'b1;
    @(negedge clk) chk("R2 busy bit", status, st(0, 2'b00, 0, 1));
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latch();
    sel(); p_wren(); p_wreq(11'h010); desel();
    chk("R3 same-select deny", {s_ag, s_ad}, 8'h1);
    chk("R3 wel after rise", status, st(0, 2'b00, 1, 0));
    sel(); p_wrdi(); desel();
    chk("R4 wel cleared", status, st(0, 2'b00, 0, 0));
  endtask

  task automatic t_sr_write();
    sel(); p_wrsr(8'hFF); desel();
    chk("R5 no wel deny", {s_sg, s_sd}, 8'h1);
    chk("R5 bits kept", status, 8'h20);
    set_wel();
    sel(); p_wrsr(8'hFF); desel();
    chk("R5 grant", {s_sg, s_sd}, 8'h2);
    chk("R5 only 7,3,2", status, st(1, 2'b11, 1, 0));
    busy_cycle();
    chk("R12 wel clears at busy fall", status, st(1, 2'b11, 0, 0));
    do_sr(8'h00, 1'b1, "R9 wpen=1 pin high");
    chk("R9 cleared", status, 8'h20);
  endtask

  task automatic t_ranges();
    logic [10:0] al [6] = '{11'h000, 11'h3FF, 11'h400, 11'h5FF, 11'h600, 11'h7FF};
    for (int c = 0; c < 4; c++) begin
      do_sr(8'(c << 2), 1'b1, "R6 set code");
      for (int i = 0; i < 6; i++) begin
        logic prot;
        prot = (c == 3) || (c == 2 && al[i] >= 11'h400) || (c == 1 && al[i] >= 11'h600);
        do_arr(al[i], ~prot, "R6 range");
      end
    end
    do_sr(8'h04, 1'b1, "R7 set quarter");
    do_arr(11'h5FF, 1'b1, "R7 page below");
    do_arr(11'h61F, 1'b0, "R7 page inside");
  endtask

  task automatic t_hw_lock();
    do_sr(8'h84, 1'b1, "R8 set wpen");
    @(negedge clk) wp_n = 1'b0;
    set_wel();
    sel(); p_wrsr(8'h00); desel();
    chk("R8 sr deny", {s_sg, s_sd}, 8'h1);
    chk("R8 bits kept", status, st(1, 2'b01, 1, 0));
    sel(); p_wreq(11'h100); desel();
    chk("R8 array grant", {s_ag, s_ad}, 8'h2);
    busy_cycle();
    @(negedge clk) wp_n = 1'b1;
    set_wel();
    sel(); p_wrsr(8'h00);
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk) wp_n = 1'b1;
    desel();
    chk("R10 abort deny", {s_sg, s_sd}, 8'h1);
    chk("R10 bits kept", status, st(1, 2'b01, 1, 0));
    sel(); p_wrdi(); desel();
    do_sr(8'h00, 1'b1, "R9 pin high grant");
    @(negedge clk) wp_n = 1'b0;
    do_sr(8'h08, 1'b1, "R9 wpen=0 pin low");
    chk("R9 bits", status, st(0, 2'b10, 0, 0));
    do_sr(8'h00, 1'b1, "R9 restore");
    @(negedge clk) wp_n = 1'b1;
  endtask

  task automatic t_busy();
    @(negedge clk) busy = 1'b1;
    sel(); p_wren(); desel();
    chk("R11 wren ignored", status, st(0, 2'b00, 0, 1));
    set_wel();
    sel(); p_wreq(11'h000); desel();
    chk("R11 no decision", {s_ag, s_ad}, 8'h0);
    sel(); p_wrsr(8'h8C); desel();
    chk("R11 sr ignored", {s_sg, s_sd}, 8'h0);
    @(negedge clk) busy = 1'b0;
    @(negedge clk) chk("R11 state kept", status, 8'h20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_sr_write();
    t_ranges();
    t_hw_lock();
    t_busy();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule